// File: doc/BRIEF.md
# Operator Console Keyboard/Printer Adapter

This block sits between a processor and a typewriter-style operator console. On the keyboard side it accepts a character strobe with an 8-bit code and single-cycle strobes for four special keys (Request, Return, End, Cancel). It records which keys were pressed, keeps interrupt-pending flags for two key classes, and drives the Proceed and Request Pending lamps. On the printer side it holds one output character and runs a print or carrier-return cycle of fixed length.

The processor talks to the block through three ports. A command port carries a modifier (0 selects the keyboard, 1 the printer) and a control byte. A load port takes a 16-bit field whose high byte becomes the output character. A sense port returns the typed character and a status byte. One level-sensitive interrupt request combines every pending flag with the enable of its class.

The printer sequencer is a three-state machine. `PS_IDLE` moves to `PS_PRINT` on a start-print command, or to `PS_RETURN` on a carrier-return command. `PS_PRINT` and `PS_RETURN` each count down `PRINT_CYCLES` cycles and then go back to `PS_IDLE`; that last transition raises the done pulse. The keyboard side is flag registers with no sequencing.

Top module: `con_adapter`

## Requirements
- R1: After reset these are all 0: every pending flag, every key flag, both lamps, every enable, the typed character, the output character, busy, done and irq. The printer is in `PS_IDLE`.
- R2: A keyboard command (`cmd_valid` with `cmd_mod`=0) loads the following from its control byte: `lamp_reqpend` from bit 5 (0x20), `lamp_proceed` from bit 4 (0x10), the Request-key interrupt enable from bit 2 (0x04) and the other-key interrupt enable from bit 1 (0x02).
- R3: Sense status byte layout: bit 7 (0x80) is Request interrupt pending, bit 6 (0x40) is End-or-Cancel interrupt pending, bit 5 (0x20) is Cancel pressed, bit 4 (0x10) is End pressed, bit 3 (0x08) is Return-or-data interrupt pending, bit 2 (0x04) is Return pressed, and bits 1:0 are 0. Each strobe sets its own bits on the next edge.
- R4: A data key strobe stores `key_char` as the typed character and sets bit 3. A second strobe that arrives while bit 3 is still set overwrites the character, and bit 3 stays set.
- R5: End sets bit 4 and clears bit 5. Cancel sets bit 5 and clears bit 4. Both set bit 6. Return sets bits 2 and 3. A data key clears bit 2 unless Return is strobed in the same cycle.
- R6: Keyboard control bit 0 (0x01) clears bits 7..2 of the status byte. A strobe in the same cycle still sets its own bits.
- R7: A pending flag sets whatever its enable is. It stays set until the matching clear bit is written.
- R8: `irq` is 1 exactly when at least one of these holds: Request pending with Request enable; End/Cancel or Return/data pending with other-key enable; printer pending with printer enable.
- R9: A printer command (`cmd_mod`=1) given in `PS_IDLE` starts a print if bit 7 (0x80) is set, otherwise a carrier return if bit 6 (0x40) is set. Either operation holds `prt_busy` for `PRINT_CYCLES` cycles, and `prt_cr` is 1 only during a return. Start bits are ignored while busy.
- R10: `prt_done` is 1 in the last busy cycle, and the printer pending flag sets on the next edge. Printer control bit 0 (0x01) clears the flag, but a flag set in the same cycle wins. Bit 2 (0x04) loads the printer interrupt enable.
- R11: A load (`ld_valid`) puts bits 15:8 of `ld_word` into `prt_char` if the printer is idle. A load while busy is ignored.
- R12: With `sns_fn`=1, `sns_data` is {typed character, status byte}. Every other function, 3 included, returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Data key strobe |
| key_char | input | 8 | Data key code |
| key_req | input | 1 | Request key strobe |
| key_ret | input | 1 | Return key strobe |
| key_end | input | 1 | End key strobe |
| key_can | input | 1 | Cancel key strobe |
| cmd_valid | input | 1 | Command strobe |
| cmd_mod | input | 1 | 0 keyboard, 1 printer |
| cmd_ctl | input | 8 | Control byte |
| ld_valid | input | 1 | Output-character load strobe |
| ld_word | input | 16 | Two-byte field; high byte is the character |
| sns_fn | input | 3 | Sense function select |
| sns_data | output | 16 | Sense word |
| lamp_proceed | output | 1 | Proceed lamp |
| lamp_reqpend | output | 1 | Request Pending lamp |
| prt_char | output | 8 | Output character register |
| prt_busy | output | 1 | Print or return in progress |
| prt_cr | output | 1 | Current operation is a carrier return |
| prt_done | output | 1 | Last busy cycle |
| irq | output | 1 | Interrupt request |

## Verification
Random single-key strobes mixed with random commands tell several things apart. They show whether each key sets its own status bits without disturbing the others. They show whether End and Cancel exclude each other, and whether the clear bit wins or loses against a strobe in the same cycle. Random commands issued while the printer is busy separate accepted starts from ignored ones, and do the same for loads. Random enable patterns show whether each pending class reaches `irq` only through its own enable. Directed sequences cover the reset state, a full print with its done pulse and pending flag, and function 3 returning zero.

// File: rtl/con_pkg.sv
package con_pkg;
    typedef enum logic [1:0] {PS_IDLE, PS_PRINT, PS_RETURN} prt_state_e;

    // keyboard control byte bit positions
    localparam int KB_LAMP_RP = 5;
    localparam int KB_LAMP_PR = 4;
    localparam int KB_EN_REQ  = 2;
    localparam int KB_EN_OTH  = 1;
    localparam int KB_CLR     = 0;
    // printer control byte bit positions
    localparam int PR_START   = 7;
    localparam int PR_CR      = 6;
    localparam int PR_EN      = 2;
    localparam int PR_CLR     = 0;
    localparam int SNS_KBD    = 1;
endpackage

// File: rtl/con_kbd.sv
module con_kbd
    import con_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [CW-1:0] ctl,
    input  logic          key_valid,
    input  logic [CW-1:0] key_char,
    input  logic          key_req,
    input  logic          key_ret,
    input  logic          key_end,
    input  logic          key_can,
    output logic [CW-1:0] chr,
    output logic [7:0]    status,
    output logic          lamp_pr,
    output logic          lamp_rp,
    output logic          irq_kb
);
    logic rq_pend, ec_pend, dt_pend, end_f, can_f, ret_f;
    logic en_req, en_oth;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chr     <= '0;
            rq_pend <= 1'b0; ec_pend <= 1'b0; dt_pend <= 1'b0;
            end_f   <= 1'b0; can_f   <= 1'b0; ret_f   <= 1'b0;
            en_req  <= 1'b0; en_oth  <= 1'b0;
            lamp_pr <= 1'b0; lamp_rp <= 1'b0;
        end else begin
            if (cmd_wr) begin
                lamp_rp <= ctl[KB_LAMP_RP];
                lamp_pr <= ctl[KB_LAMP_PR];
                en_req  <= ctl[KB_EN_REQ];
                en_oth  <= ctl[KB_EN_OTH];
                if (ctl[KB_CLR]) begin
                    rq_pend <= 1'b0; ec_pend <= 1'b0; dt_pend <= 1'b0;
                    end_f   <= 1'b0; can_f   <= 1'b0; ret_f   <= 1'b0;
                end
            end
            // strobes come after the clear so a same-cycle key wins
            if (key_req) rq_pend <= 1'b1;
            if (key_end || key_can) ec_pend <= 1'b1;
            if (key_end) begin end_f <= 1'b1; can_f <= 1'b0; end
            if (key_can) begin can_f <= 1'b1; end_f <= 1'b0; end
            if (key_valid) begin
                dt_pend <= 1'b1;
                chr     <= key_char;
                ret_f   <= 1'b0;
            end
            if (key_ret) begin dt_pend <= 1'b1; ret_f <= 1'b1; end
        end
    end

    always_comb begin
        status = {rq_pend, ec_pend, can_f, end_f, dt_pend, ret_f, 2'b00};
        irq_kb = (rq_pend & en_req) | ((ec_pend | dt_pend) & en_oth);
    end

    AST_LAMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (lamp_pr == $past(ctl[KB_LAMP_PR]) && lamp_rp == $past(ctl[KB_LAMP_RP]))); // R2
    AST_CHAR_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> (chr == $past(key_char) && status[3])); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !(cmd_wr && ctl[KB_CLR])) |=> status[7]); // R7
endmodule

// File: rtl/con_prt.sv
module con_prt
    import con_pkg::*;
#(
    parameter int CW           = 8,
    parameter int PRINT_CYCLES = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [7:0]    ctl,
    input  logic          ld_valid,
    input  logic [CW-1:0] ld_char,
    output logic [CW-1:0] prt_char,
    output logic          prt_busy,
    output logic          prt_cr,
    output logic          prt_done,
    output logic          irq_pr
);
    localparam int TW = $clog2(PRINT_CYCLES) + 1;

    prt_state_e   state, nxt;
    logic [TW-1:0] cnt;
    logic         pend, en;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PS_IDLE: begin
                if (cmd_wr && ctl[PR_START])   nxt = PS_PRINT;
                else if (cmd_wr && ctl[PR_CR]) nxt = PS_RETURN;
            end
            PS_PRINT, PS_RETURN: if (cnt == '0) nxt = PS_IDLE;
            default: nxt = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            pend     <= 1'b0;
            en       <= 1'b0;
            prt_char <= '0;
        end else begin
            if (state == PS_IDLE) begin
                if (nxt != PS_IDLE) cnt <= TW'(PRINT_CYCLES - 1);
                if (ld_valid) prt_char <= ld_char;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (cmd_wr) begin
                en <= ctl[PR_EN];
                if (ctl[PR_CLR]) pend <= 1'b0;
            end
            if (prt_done) pend <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        prt_busy = (state != PS_IDLE);
        prt_cr   = (state == PS_RETURN);
        prt_done = prt_busy && (cnt == '0);
        irq_pr   = pend & en;
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!prt_busy && cmd_wr && ctl[PR_START]) |=> (prt_busy && !prt_cr)); // R9
    AST_DONE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        prt_done |=> pend); // R10
    AST_CHAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (prt_busy && ld_valid) |=> $stable(prt_char)); // R11
endmodule

// File: rtl/con_adapter.sv
module con_adapter
    import con_pkg::*;
#(
    parameter int CW           = 8,
    parameter int PRINT_CYCLES = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_valid,
    input  logic [CW-1:0] key_char,
    input  logic          key_req,
    input  logic          key_ret,
    input  logic          key_end,
    input  logic          key_can,
    input  logic          cmd_valid,
    input  logic          cmd_mod,
    input  logic [7:0]    cmd_ctl,
    input  logic          ld_valid,
    input  logic [2*CW-1:0] ld_word,
    input  logic [2:0]    sns_fn,
    output logic [2*CW-1:0] sns_data,
    output logic          lamp_proceed,
    output logic          lamp_reqpend,
    output logic [CW-1:0] prt_char,
    output logic          prt_busy,
    output logic          prt_cr,
    output logic          prt_done,
    output logic          irq
);
    logic [CW-1:0] chr;
    logic [7:0]    status;
    logic          irq_kb, irq_pr;

    con_kbd #(.CW(CW)) u_kbd (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_valid && !cmd_mod), .ctl(cmd_ctl),
        .key_valid(key_valid), .key_char(key_char), .key_req(key_req),
        .key_ret(key_ret), .key_end(key_end), .key_can(key_can),
        .chr(chr), .status(status), .lamp_pr(lamp_proceed),
        .lamp_rp(lamp_reqpend), .irq_kb(irq_kb)
    );

    con_prt #(.CW(CW), .PRINT_CYCLES(PRINT_CYCLES)) u_prt (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_valid && cmd_mod), .ctl(cmd_ctl),
        .ld_valid(ld_valid), .ld_char(ld_word[2*CW-1:CW]), .prt_char(prt_char),
        .prt_busy(prt_busy), .prt_cr(prt_cr), .prt_done(prt_done), .irq_pr(irq_pr)
    );

    always_comb begin
        irq      = irq_kb | irq_pr;
        sns_data = (sns_fn == 3'(SNS_KBD)) ? {chr, status[CW-1:0]} : '0;
    end

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status[7] || status[6] || status[3] || irq_pr)); // R8
endmodule

// File: tb/sim_con_adapter.sv
module sim_con_adapter;
    localparam int PC = 6;
    logic clk = 1'b0, rst_n = 1'b0;
    logic key_valid = 0, key_req = 0, key_ret = 0, key_end = 0, key_can = 0;
    logic [7:0] key_char = 0, cmd_ctl = 0;
    logic cmd_valid = 0, cmd_mod = 0, ld_valid = 0;
    logic [15:0] ld_word = 0, sns_data;
    logic [2:0] sns_fn = 3'd1;
    logic lamp_proceed, lamp_reqpend, prt_busy, prt_cr, prt_done, irq;
    logic [7:0] prt_char;
    int checks = 0, fails = 0;
    bit finished = 0;

    // reference state
    logic [7:0] m_chr, m_pch;
    logic m_rp, m_ec, m_dp, m_end, m_can, m_ret, m_lr, m_lp, m_er, m_eo;
    logic m_busy, m_cr, m_pp, m_ep;
    int m_cnt;

    con_adapter #(.CW(8), .PRINT_CYCLES(PC)) u0 (.*);

    always #2 clk = ~clk;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_status();
        return {m_rp, m_ec, m_can, m_end, m_dp, m_ret, 2'b00};
    endfunction

    task automatic model_reset();
        m_chr = 0; m_pch = 0; {m_rp, m_ec, m_dp, m_end, m_can, m_ret} = 0;
        {m_lr, m_lp, m_er, m_eo, m_busy, m_cr, m_pp, m_ep} = 0; m_cnt = 0;
    endtask

    // next state from the requirements, inputs as set before the edge
    task automatic model_step();
        logic done = m_busy && m_cnt == 0;
        if (cmd_valid && !cmd_mod) begin                         // R2 R6
            m_lr = cmd_ctl[5]; m_lp = cmd_ctl[4]; m_er = cmd_ctl[2]; m_eo = cmd_ctl[1];
            if (cmd_ctl[0]) {m_rp, m_ec, m_dp, m_end, m_can, m_ret} = 0;
        end
        if (key_req) m_rp = 1;
        if (key_end || key_can) m_ec = 1;
        if (key_end) begin m_end = 1; m_can = 0; end
        if (key_can) begin m_can = 1; m_end = 0; end
        if (key_valid) begin m_dp = 1; m_chr = key_char; m_ret = 0; end
        if (key_ret) begin m_dp = 1; m_ret = 1; end
        if (!m_busy && ld_valid) m_pch = ld_word[15:8];        // R11
        if (m_busy) begin
            if (m_cnt == 0) begin m_busy = 0; m_cr = 0; end else m_cnt--;
        end else if (cmd_valid && cmd_mod && (cmd_ctl[7] || cmd_ctl[6])) begin
            m_busy = 1; m_cnt = PC - 1; m_cr = !cmd_ctl[7];
        end
        if (cmd_valid && cmd_mod) begin
            m_ep = cmd_ctl[2];
            if (cmd_ctl[0]) m_pp = 0;
        end
        if (done) m_pp = 1;
    endtask

    task automatic compare();
        logic exp_irq = (m_rp & m_er) | ((m_ec | m_dp) & m_eo) | (m_pp & m_ep);
        chk("R2 lamps", {lamp_reqpend, lamp_proceed}, {m_lr, m_lp});
        chk("R8 irq", irq, exp_irq);
        chk("R9 busy/cr", {prt_busy, prt_cr}, {m_busy, m_cr});
        chk("R10 done", prt_done, m_busy && m_cnt == 0);
        chk("R11 prt_char", prt_char, m_pch);
        chk("R3 R4 R5 R6 R7 R12 sense", sns_data,
            (sns_fn == 3'd1) ? {m_chr, m_status()} : 16'h0000);
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        {key_valid, key_req, key_ret, key_end, key_can, cmd_valid, ld_valid} = 0;
    endtask

    task automatic cmd(logic m, logic [7:0] c);
        cmd_valid = 1; cmd_mod = m; cmd_ctl = c; cycle();
    endtask

    initial begin
        #200000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare();                                     // R1 reset state
        chk("R1 irq after reset", irq, 1'b0);
        // directed: Request interrupt held, then cleared
        key_req = 1; cycle();
        chk("R7 pending without enable", sns_data[7], 1'b1);
        cmd(0, 8'h34);                                 // lamp proceed, lamp req, req enable
        chk("R8 irq request class", irq, 1'b1);
        cmd(0, 8'h01);
        chk("R6 clear", sns_data[7:0], 8'h00);
        // data key twice while pending, then Return / End / Cancel
        key_valid = 1; key_char = 8'hC1; cycle();
        key_valid = 1; key_char = 8'hC2; cycle();
        chk("R4 overwrite", sns_data, 16'hC208);
        key_ret = 1; cycle(); key_end = 1; cycle(); key_can = 1; cycle();
        chk("R5 cancel after end", sns_data[7:0], 8'h6C);
        // printer: load, print, load while busy, done
        ld_word = 16'h5A33; ld_valid = 1; cycle();
        cmd(1, 8'hC4);
        ld_word = 16'h7700; ld_valid = 1; cycle();
        repeat (PC + 1) cycle();
        chk("R11 load ignored when busy", prt_char, 8'h5A);
        chk("R10 printer irq", irq, 1'b1);
        cmd(1, 8'h40);
        chk("R9 carrier return", {prt_busy, prt_cr}, 2'b11);
        repeat (PC + 1) cycle();
        sns_fn = 3'd3; cycle();
        chk("R12 fn3 zero", sns_data, 16'h0000);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int k = $urandom_range(0, 15);
            key_char  = 8'($urandom);
            key_valid = (k == 0); key_req = (k == 1); key_ret = (k == 2);
            key_end   = (k == 3); key_can = (k == 4);
            cmd_valid = ($urandom_range(0, 6) == 0);
            cmd_mod   = 1'($urandom);
            cmd_ctl   = 8'($urandom);
            ld_valid  = ($urandom_range(0, 5) == 0);
            ld_word   = 16'($urandom);
            sns_fn    = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd1;
            cycle();
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule